// File: doc/BRIEF.md
# Buffered SPI Burst Host

This block is a memory-mapped SPI master that moves a whole burst of bytes on its own once software starts it. Software fills an on-chip transmit store of up to 320 bytes through a simple byte-addressed register bus. It then writes one control word that carries the byte count, a 3-bit clock speed code, the clock mode, the target device and a start bit. The engine shifts the bytes out most-significant bit first. Each byte that comes back on the input line is stored in a receive store at the same position as the byte sent in that slot.

When the burst ends the start bit drops and a sticky completion flag is raised. Software clears the flag by writing one to it. The interrupt line is the flag gated by a mask bit. Seven active-low device selects are available. A hold-select bit keeps the chosen device selected between bursts, so one longer transaction can be built from several bursts. The SPI clock is divided from the system clock. Only two clock modes exist: mode 0, where the clock idles low, and mode 3, where it idles high. In both modes input data is sampled on the rising clock edge and output data changes on the falling edge.

Top module: `spi_burst_host`

## Requirements
- R1: After reset all device selects are high, irq is 0, SCK is 0, the control word reads 0, the event word reads 0 and the mask word reads 0x100 (interrupt masked).
- R2: A bus write to byte address A in 0x000..0x13F stores bus_wdata[7:0] in transmit slot A, and a bus read of that address returns it in bus_rdata[7:0] on the cycle after bus_rd.
- R3: A start sends exactly the programmed number of bytes from the transmit store, slot 0 first and each byte MSB first on MOSI. There are 8 rising SCK edges per byte.
- R4: The byte received in slot i is readable at byte address 0x200+i once the burst ends.
- R5: Control bit 2 picks the clock mode: 0 gives SCK idle low (mode 0) and 1 gives SCK idle high (mode 3). In both modes MISO is sampled on rising SCK edges.
- R6: Control bits [7:5] hold the speed code. The SCK half-period is 1, 2, 2, 3 or 3 system cycles for codes 2 to 6, and 16 cycles for code 7. Codes 0 and 1 behave as code 2.
- R7: Writing control bit 0 as 1 while idle starts a burst. The bit reads 1 until the burst ends, then it reads 0 and event bit 8 is set. Writing 1 to event bit 8 clears it, and writing 0 leaves it unchanged.
- R8: irq equals event bit 8 AND NOT mask bit 8.
- R9: cs_n[k] is low only while control bits [27:25] equal k and a burst is running or the hold bit is set. A value of 7 selects no line, and at most one line is ever low.
- R10: While control bit 4 (hold select) is 1, the selected line stays low between bursts. Clearing the bit releases it.
- R11: A control write during a running burst has no effect on any control field, the device select or the byte count.
- R12: Control bits [16:8] give the byte count. A count of 0 with start sets event bit 8 on the next cycle with no SCK edge. A count above 320 runs 320 bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register/store write strobe |
| bus_rd | input | 1 | Register/store read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Completion interrupt, level |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 7 | Active-low device selects |

## Verification
A wrong byte or bit counter shows up within a single burst. The receive store then holds a shifted copy of the echoed stream, and the number of rising SCK edges differs from eight per byte as soon as the burst finishes. A wrong divider state shows in the time between the first two rising edges, and a wrong clock polarity shows in the SCK idle level right after the mode is written. A stuck start bit or event flag shows on the next poll of the status words. A bad select decode is visible on cs_n a few cycles into the burst, because the slave model then sees no selection and echoes nothing.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    localparam int unsigned HALF_W = 5;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_LOW,
        PH_HIGH,
        PH_HOLD
    } phase_e;

    // speed code -> SCK half-period in system cycles
    function automatic logic [HALF_W-1:0] half_of_code(input logic [2:0] code);
        logic [HALF_W-1:0] h;
        case (code)
            3'd7:       h = HALF_W'(16);
            3'd0, 3'd1: h = HALF_W'(1);
            default:    h = HALF_W'(({2'b00, code} + 5'd1) >> 1);
        endcase
        return h;
    endfunction

endpackage

// File: rtl/spi_byte_ram.sv
module spi_byte_ram #(
    parameter int unsigned DEPTH    = 320,
    parameter int unsigned IDX_W    = 9,
    parameter int unsigned RD_PORTS = 1
) (
    input  logic                               clk,
    input  logic                               we,
    input  logic [IDX_W-1:0]                   widx,
    input  logic [7:0]                         wdata,
    input  logic [RD_PORTS-1:0][IDX_W-1:0]     raddr,
    output logic [RD_PORTS-1:0][7:0]           rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (32'(widx) < DEPTH)) begin
            mem[widx] <= wdata;
        end
    end

    for (genvar g = 0; g < RD_PORTS; g++) begin : g_rd
        always_comb begin
            rdata[g] = (32'(raddr[g]) < DEPTH) ? mem[raddr[g]] : 8'h00;
        end
    end

endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
    parameter int unsigned HALF_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              tick
);

    logic [HALF_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == half - HALF_W'(1));
        cnt_d = (!run || tick) ? '0 : cnt_q + HALF_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_burst_pkg::*;
#(
    parameter int unsigned LEN_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  len,
    input  logic [HALF_W-1:0] half,
    input  logic              cpol,
    output logic [LEN_W-1:0]  cmd_idx,
    input  logic [7:0]        cmd_byte,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              rsp_we,
    output logic [LEN_W-1:0]  rsp_idx,
    output logic [7:0]        rsp_byte,
    output logic              busy,
    output logic              done
);

    typedef struct packed {
        phase_e            phase;
        logic [2:0]        bit_idx;
        logic [LEN_W-1:0]  byte_idx;
        logic [LEN_W-1:0]  last_idx;
        logic [7:0]        rx;
        logic [HALF_W-1:0] half;
    } eng_t;

    eng_t st_d, st_q;
    logic tick;

    spi_clk_div #(.HALF_W(HALF_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .half  (st_q.half),
        .tick  (tick)
    );

    always_comb begin
        st_d   = st_q;
        rsp_we = 1'b0;
        done   = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase    = PH_SETUP;
                    st_d.bit_idx  = '0;
                    st_d.byte_idx = '0;
                    st_d.last_idx = len - LEN_W'(1);
                    st_d.rx       = '0;
                    st_d.half     = half;
                end
            end
            PH_SETUP: if (tick) st_d.phase = PH_LOW;
            PH_LOW: begin
                if (tick) begin
                    st_d.phase = PH_HIGH;
                    st_d.rx    = {st_q.rx[6:0], miso};
                end
            end
            PH_HIGH: begin
                if (tick) begin
                    if (st_q.bit_idx == 3'd7) begin
                        rsp_we = 1'b1;
                        if (st_q.byte_idx == st_q.last_idx) begin
                            st_d.phase = PH_HOLD;
                        end else begin
                            st_d.phase    = PH_LOW;
                            st_d.bit_idx  = '0;
                            st_d.byte_idx = st_q.byte_idx + LEN_W'(1);
                        end
                    end else begin
                        st_d.phase   = PH_LOW;
                        st_d.bit_idx = st_q.bit_idx + 3'd1;
                    end
                end
            end
            PH_HOLD: begin
                if (tick) begin
                    st_d.phase = PH_IDLE;
                    done       = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, bit_idx: '0, byte_idx: '0,
                      last_idx: '0, rx: '0, half: HALF_W'(1)};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        busy     = (st_q.phase != PH_IDLE);
        cmd_idx  = st_q.byte_idx;
        rsp_idx  = st_q.byte_idx;
        rsp_byte = st_q.rx;
        mosi     = cmd_byte[3'd7 - st_q.bit_idx];
        case (st_q.phase)
            PH_LOW:  sck = 1'b0;
            PH_HIGH: sck = 1'b1;
            default: sck = cpol;
        endcase
    end

endmodule

// File: rtl/spi_burst_host.sv
module spi_burst_host
    import spi_burst_pkg::*;
#(
    parameter int unsigned BUF_BYTES = 320,
    parameter int unsigned CS_COUNT  = 7,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                irq,
    output logic                sck,
    output logic                mosi,
    input  logic                miso,
    output logic [CS_COUNT-1:0] cs_n
);

    localparam int unsigned IDX_W = $clog2(BUF_BYTES);
    localparam int unsigned LEN_W = $clog2(BUF_BYTES + 1);
    localparam logic [ADDR_W-1:0] CMD_END  = ADDR_W'(BUF_BYTES);
    localparam logic [ADDR_W-1:0] RSP_BASE = ADDR_W'('h200);
    localparam logic [ADDR_W-1:0] RSP_END  = RSP_BASE + ADDR_W'(BUF_BYTES);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'('h400);
    localparam logic [ADDR_W-1:0] EVT_ADDR = ADDR_W'('h420);
    localparam logic [ADDR_W-1:0] MSK_ADDR = ADDR_W'('h424);

    typedef struct packed {
        logic [2:0]  devsel;
        logic [8:0]  len;
        logic [2:0]  speed;
        logic        force_cs;
        logic        mode;
        logic        go;
        logic        evt;
        logic        mask;
        logic        start;
        logic [31:0] rdata;
    } host_t;

    host_t st_d, st_q;

    logic             in_cmd, in_rsp, hit_ctl, hit_evt, hit_msk;
    logic [LEN_W-1:0] len_eff;
    logic [7:0]       cmd_bus_byte, cmd_eng_byte, rsp_bus_byte;
    logic [LEN_W-1:0] eng_cmd_idx, eng_rsp_idx;
    logic [7:0]       eng_rsp_byte;
    logic             eng_rsp_we, eng_busy, eng_done;
    logic             go_w, mode_w;
    logic             unused_wdata;

    always_comb begin
        in_cmd  = bus_addr < CMD_END;
        in_rsp  = (bus_addr >= RSP_BASE) && (bus_addr < RSP_END);
        hit_ctl = bus_wr && (bus_addr == CTL_ADDR);
        hit_evt = bus_wr && (bus_addr == EVT_ADDR);
        hit_msk = bus_wr && (bus_addr == MSK_ADDR);
        len_eff = (32'(st_q.len) > BUF_BYTES) ? LEN_W'(BUF_BYTES) : LEN_W'(st_q.len);
        unused_wdata = ^{bus_wdata[31:28], bus_wdata[24:17], bus_wdata[3], bus_wdata[1]};
    end

    spi_byte_ram #(.DEPTH(BUF_BYTES), .IDX_W(IDX_W), .RD_PORTS(2)) u_cmd_ram (
        .clk   (clk),
        .we    (bus_wr && in_cmd),
        .widx  (IDX_W'(bus_addr)),
        .wdata (bus_wdata[7:0]),
        .raddr ({IDX_W'(eng_cmd_idx), IDX_W'(bus_addr)}),
        .rdata ({cmd_eng_byte, cmd_bus_byte})
    );

    spi_byte_ram #(.DEPTH(BUF_BYTES), .IDX_W(IDX_W), .RD_PORTS(1)) u_rsp_ram (
        .clk   (clk),
        .we    (eng_rsp_we),
        .widx  (IDX_W'(eng_rsp_idx)),
        .wdata (eng_rsp_byte),
        .raddr (IDX_W'(bus_addr - RSP_BASE)),
        .rdata (rsp_bus_byte)
    );

    spi_shift_engine #(.LEN_W(LEN_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (st_q.start),
        .len      (len_eff),
        .half     (half_of_code(st_q.speed)),
        .cpol     (st_q.mode),
        .cmd_idx  (eng_cmd_idx),
        .cmd_byte (cmd_eng_byte),
        .miso     (miso),
        .sck      (sck),
        .mosi     (mosi),
        .rsp_we   (eng_rsp_we),
        .rsp_idx  (eng_rsp_idx),
        .rsp_byte (eng_rsp_byte),
        .busy     (eng_busy),
        .done     (eng_done)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (hit_ctl && !st_q.go) begin
            st_d.devsel   = bus_wdata[27:25];
            st_d.len      = bus_wdata[16:8];
            st_d.speed    = bus_wdata[7:5];
            st_d.force_cs = bus_wdata[4];
            st_d.mode     = bus_wdata[2];
            if (bus_wdata[0]) begin
                if (bus_wdata[16:8] == 9'd0) begin
                    st_d.evt = 1'b1;
                end else begin
                    st_d.go    = 1'b1;
                    st_d.start = 1'b1;
                end
            end
        end
        if (hit_evt && bus_wdata[8]) st_d.evt = 1'b0;
        if (eng_done) begin
            st_d.go  = 1'b0;
            st_d.evt = 1'b1;
        end
        if (hit_msk) st_d.mask = bus_wdata[8];
        if (bus_rd) begin
            if (in_cmd)                      st_d.rdata = {24'h0, cmd_bus_byte};
            else if (in_rsp)                 st_d.rdata = {24'h0, rsp_bus_byte};
            else if (bus_addr == CTL_ADDR)   st_d.rdata = {4'h0, st_q.devsel, 8'h00, st_q.len,
                                                           st_q.speed, st_q.force_cs, 1'b0,
                                                           st_q.mode, 1'b0, st_q.go};
            else if (bus_addr == EVT_ADDR)   st_d.rdata = {23'h0, st_q.evt, 8'h00};
            else if (bus_addr == MSK_ADDR)   st_d.rdata = {23'h0, st_q.mask, 8'h00};
            else                             st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar k = 0; k < CS_COUNT; k++) begin : g_cs
        always_comb begin
            cs_n[k] = ~((st_q.force_cs || st_q.go || eng_busy) &&
                        (32'(st_q.devsel) == k));
        end
    end

    always_comb begin
        bus_rdata = st_q.rdata;
        irq       = st_q.evt & ~st_q.mask;
        go_w      = st_q.go;
        mode_w    = st_q.mode;
    end

endmodule

// File: rtl/spi_burst_host_chk.sv
module spi_burst_host_chk #(
    parameter int unsigned CS_COUNT = 7,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned LEN_W    = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic [CS_COUNT-1:0] cs_n,
    input logic                sck,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                go,
    input logic                evt,
    input logic                mode,
    input logic [2:0]          devsel,
    input logic [8:0]          len,
    input logic [2:0]          speed,
    input logic                force_cs,
    input logic                eng_busy,
    input logic                eng_done,
    input logic                rsp_we,
    input logic [LEN_W-1:0]    rsp_idx,
    input logic [LEN_W-1:0]    len_eff
);

    // R9
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R11
    ctl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && bus_wr && bus_addr == ADDR_W'('h400)) |=>
            $stable({devsel, len, speed, force_cs, mode}));

    // R7
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> evt);

    // R7
    go_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(go) |-> $past(eng_done));

    // R4
    rsp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_we |-> (rsp_idx < len_eff));

    // R5
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> (sck == mode));

endmodule

bind spi_burst_host spi_burst_host_chk #(
    .CS_COUNT (CS_COUNT),
    .ADDR_W   (ADDR_W),
    .LEN_W    (LEN_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sck      (sck),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .go       (go_w),
    .evt      (st_q.evt),
    .mode     (mode_w),
    .devsel   (st_q.devsel),
    .len      (st_q.len),
    .speed    (st_q.speed),
    .force_cs (st_q.force_cs),
    .eng_busy (eng_busy),
    .eng_done (eng_done),
    .rsp_we   (eng_rsp_we),
    .rsp_idx  (eng_rsp_idx),
    .len_eff  (len_eff)
);

// File: tb/spi_burst_host_tb.sv
`timescale 1ns/1ps
module spi_burst_host_tb;

    localparam int BUF = 320;
    localparam logic [11:0] A_CTL = 12'h400;
    localparam logic [11:0] A_EVT = 12'h420;
    localparam logic [11:0] A_MSK = 12'h424;
    localparam logic [11:0] A_RSP = 12'h200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, sck, mosi;
    logic        miso = 1'b0;
    logic [6:0]  cs_n;
    logic        cs_any;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] cmd_img [BUF];
    logic [7:0] s_log [512];
    int   s_nb = 0;
    int   rises = 0;
    int   s_cnt = 0;
    time  t1 = 0, t2 = 0;
    logic [7:0] s_tx = 8'h00, s_rx = 8'h00, prev_last = 8'h00;

    always #2.5 clk = ~clk;

    spi_burst_host u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    assign cs_any = ~&cs_n;

    // slave model: first byte 0xA5 after selection, then echoes previous byte
    always @(posedge cs_any) begin
        s_tx  = 8'hA5;
        s_cnt = 0;
        miso  = s_tx[7];
    end

    always @(posedge sck) begin
        rises++;
        if (rises == 1) t1 = $time;
        if (rises == 2) t2 = $time;
        if (cs_any) begin
            s_rx = {s_rx[6:0], mosi};
            s_cnt++;
            if (s_cnt == 8) begin
                if (s_nb < 512) s_log[s_nb] = s_rx;
                s_nb++;
                s_tx  = s_rx;
                s_cnt = 0;
            end
        end
    end

    always @(negedge sck) begin
        if (cs_any) miso = s_tx[7 - s_cnt];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] cw(input int dev, input int len, input int code,
                                       input bit frc, input bit mode, input bit go);
        return {4'h0, 3'(dev), 8'h00, 9'(len), 3'(code), frc, 1'b0, mode, 1'b0, go};
    endfunction

    task automatic run_burst(input bit mode, input int code, input int dev, input bit frc,
                             input int lenf, input bit fresh, input bit datachk);
        int leff, half, bad, npoll;
        logic [31:0] v;
        logic [7:0]  ex;
        leff = (lenf > BUF) ? BUF : lenf;
        half = (code == 7) ? 16 : ((code < 2) ? 1 : (code + 1) / 2);
        wr(A_CTL, cw(dev, lenf, code, frc, mode, 1'b0));
        rises = 0; s_nb = 0; t1 = 0; t2 = 0;
        wr(A_CTL, cw(dev, lenf, code, frc, mode, 1'b1));
        if (leff > 0) begin
            repeat (2) @(negedge clk);
            // R9 selected line low while running
            chk("R9 select during burst", {25'h0, cs_n},
                {25'h0, (dev < 7) ? ~(7'(1) << dev) : 7'h7F});
        end
        v = '0; npoll = 0;
        while (!v[8]) begin
            rd(A_EVT, v);
            npoll++;
        end
        // R12 zero count completes at once
        if (leff == 0) chk("R12 zero-length event", npoll, 1);
        chk("R3 rising edges", rises, 8 * leff);
        if (datachk) begin
            bad = 0;
            for (int i = 0; i < leff; i++) if (s_log[i] !== cmd_img[i]) bad++;
            chk("R3 bytes seen by slave", s_nb, leff);
            chk("R3 MOSI byte mismatches", bad, 0);
            bad = 0;
            for (int i = 0; i < leff; i++) begin
                rd(A_RSP + 12'(i), v);
                ex = (i == 0) ? (fresh ? 8'hA5 : prev_last) : cmd_img[i-1];
                if (v[7:0] !== ex) bad++;
            end
            chk("R4 receive store mismatches", bad, 0);
        end
        if (leff > 1) chk("R6 SCK period ns", 32'(t2 - t1), 32'(10 * half));
        chk("R5 SCK idle level", {31'h0, sck}, {31'h0, mode});
        rd(A_CTL, v);
        chk("R7 start bit cleared", {31'h0, v[0]}, 32'h0);
        chk("R10 select after burst", {25'h0, cs_n},
            {25'h0, (frc && dev < 7) ? ~(7'(1) << dev) : 7'h7F});
        if (leff > 0) prev_last = cmd_img[leff-1];
        wr(A_EVT, 32'h100);
        rd(A_EVT, v);
        chk("R7 event cleared by write-one", {31'h0, v[8]}, 32'h0);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        int bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 selects", {25'h0, cs_n}, 32'h7F);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 sck", {31'h0, sck}, 32'h0);
        rd(A_CTL, v); chk("R1 control", v, 32'h0);
        rd(A_EVT, v); chk("R1 event", v, 32'h0);
        rd(A_MSK, v); chk("R1 mask", v, 32'h100);

        // R2 fill and read back the transmit store
        for (int i = 0; i < BUF; i++) begin
            cmd_img[i] = 8'((i * 37 + 11) & 8'hFF);
            wr(12'(i), {24'h0, cmd_img[i]});
        end
        bad = 0;
        for (int i = 0; i < BUF; i++) begin
            rd(12'(i), v);
            if (v[7:0] !== cmd_img[i]) bad++;
        end
        chk("R2 transmit store readback", bad, 0);

        // R3 R4 basic burst
        run_burst(1'b0, 2, 3, 1'b0, 5, 1'b1, 1'b1);

        // R8 interrupt gating, R7 write-zero keeps flag
        wr(A_CTL, cw(0, 1, 2, 1'b0, 1'b0, 1'b1));
        v = '0;
        while (!v[8]) rd(A_EVT, v);
        chk("R8 irq masked", {31'h0, irq}, 32'h0);
        wr(A_MSK, 32'h0);
        @(negedge clk);
        chk("R8 irq unmasked", {31'h0, irq}, 32'h1);
        wr(A_EVT, 32'h0);
        @(negedge clk);
        chk("R7 write zero keeps event", {31'h0, irq}, 32'h1);
        wr(A_EVT, 32'h100);
        @(negedge clk);
        chk("R8 irq after clear", {31'h0, irq}, 32'h0);
        wr(A_MSK, 32'h100);
        prev_last = cmd_img[0];

        // R5 R6 sweep modes and speed codes
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 8; c++) begin
                if (c != 1) run_burst(m[0], c, c % 7, 1'b0, 3, 1'b1, 1'b1);
            end
        end

        // R10 held selection across bursts
        wr(A_CTL, cw(5, 2, 4, 1'b1, 1'b0, 1'b0));
        @(negedge clk);
        chk("R10 hold asserts select", {25'h0, cs_n}, {25'h0, ~(7'(1) << 5)});
        run_burst(1'b0, 4, 5, 1'b1, 2, 1'b1, 1'b1);
        run_burst(1'b0, 4, 5, 1'b1, 3, 1'b0, 1'b1);
        wr(A_CTL, cw(5, 2, 4, 1'b0, 1'b0, 1'b0));
        @(negedge clk);
        chk("R10 hold release", {25'h0, cs_n}, 32'h7F);

        // R11 control write during burst ignored
        wr(A_CTL, cw(1, 4, 3, 1'b0, 1'b0, 1'b0));
        s_nb = 0;
        wr(A_CTL, cw(1, 4, 3, 1'b0, 1'b0, 1'b1));
        wr(A_CTL, cw(6, 9, 5, 1'b1, 1'b1, 1'b1));
        @(negedge clk);
        chk("R11 select unchanged", {25'h0, cs_n}, {25'h0, ~(7'(1) << 1)});
        v = '0;
        while (!v[8]) rd(A_EVT, v);
        rd(A_CTL, v);
        chk("R11 control unchanged", v, cw(1, 4, 3, 1'b0, 1'b0, 1'b0));
        chk("R11 byte count unchanged", s_nb, 4);
        wr(A_EVT, 32'h100);

        // R12 zero length and clamp
        run_burst(1'b0, 2, 4, 1'b0, 0, 1'b1, 1'b1);
        run_burst(1'b0, 2, 2, 1'b0, 400, 1'b1, 1'b1);

        // R9 select value 7 drives no line
        run_burst(1'b0, 2, 7, 1'b0, 2, 1'b1, 1'b0);

        summary();
        $finish;
    end

endmodule